// File: doc/BRIEF.md
# Keyboard Controller Output Port with Timed Pulse

This block holds the eight-bit output port of a keyboard controller. The command processor either replaces the port with a full byte, or asks for a timed pulse: a four-bit active-low mask picks which of the four lowest port bits are pulled low for a fixed number of clock cycles. After that interval the pulled bits return to the values they held before. Port bit 0 drives the active-low system reset line, so pulsing it produces a reset of known length. Bit 1 gates address line 20. Bits 6 and 7 drive the keyboard clock and data lines.

Bits 4 and 5 are not stored in the block. They follow the controller's output-buffer-full flag and the inverse of its input-buffer-full flag. A write or pulse request that arrives while a pulse is running is held in a one-deep slot of its own kind and is applied once the pulse ends. A `busy` output is high for as long as a pulse is being driven.

Top module: `kbc_output_port`

## Requirements
- R1: With no pulse running, a write (`wr_en` high) loads `wr_data` bits 7:6 and 3:0 into the same port bits, and the new value is visible in the cycle after the write edge. Bit 0 is the active-low system reset, bit 1 is the A20 gate, bit 6 is keyboard clock and bit 7 is keyboard data.
- R2: Port bit 4 always equals `obf` and port bit 5 always equals the inverse of `ibf`, without waiting for a clock edge. Bits 5:4 of `wr_data` are ignored.
- R3: After reset the stored port bits equal `RESET_VALUE` (default FFh, so system reset is deasserted) and `busy` is 0.
- R4: A pulse request (`pulse_en` high) on an idle port drives low every port bit i in 3:0 whose `pulse_mask` bit i is 0. These bits are low, and `busy` is high, for exactly `PULSE_CYCLES` cycles starting the cycle after the request. A 0 in mask bit 0 therefore asserts system reset for that interval.
- R5: During a pulse, unselected bits keep their values. When the pulse ends, the pulsed bits return to their stored values.
- R6: A pulse request whose mask is 4'hF has no effect: `busy` stays 0 and the port is unchanged.
- R7: A write during a pulse does not change the port while `busy` is high. The most recent such write is applied in the first cycle after `busy` falls.
- R8: A pulse request with a non-F mask that arrives during a pulse is held, and only the most recent one is kept. It starts after exactly one cycle with `busy` low.
- R9: A write and a pulse request in the same idle cycle both take effect: the pulse acts on the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Full-byte write strobe |
| wr_data | input | 8 | Byte to write to the port |
| pulse_en | input | 1 | Pulse request strobe |
| pulse_mask | input | 4 | Active-low selection of port bits 3:0 to pulse |
| obf | input | 1 | Output-buffer-full flag, shown on bit 4 |
| ibf | input | 1 | Input-buffer-full flag, shown inverted on bit 5 |
| port_q | output | 8 | Output port value |
| busy | output | 1 | High while a pulse is driven |

## Verification
A wrong pulse counter shows directly at the ports. If the pulse is one cycle too long or too short, `busy` and the low bits fall on the wrong cycle, and the test counts this edge against `PULSE_CYCLES`. A corrupted hold slot becomes visible only when the pulse ends. It then appears as a wrong port byte in the first idle cycle, or as a second pulse with the wrong bits or missing its one-cycle gap. A mistake in the stored bits appears one cycle after the write that should have set them.

// File: rtl/kbc_output_port.sv
module kbc_output_port #(
  parameter int          PULSE_CYCLES = 1200,
  parameter logic [7:0]  RESET_VALUE  = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       pulse_en,
  input  logic [3:0] pulse_mask,
  input  logic       obf,
  input  logic       ibf,
  output logic [7:0] port_q,
  output logic       busy
);
  localparam int CW = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYCLES - 1);
  localparam logic [3:0] NO_PULSE = 4'hF;

  logic [1:0]    hi_q;
  logic [3:0]    lo_q;
  logic [3:0]    drive_lo;
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          wh_v;
  logic [5:0]    wh_d;
  logic          ph_v;
  logic [3:0]    ph_m;

  logic       unused_bits;
  logic [5:0] wr6;
  logic       new_req;
  logic       ending;

  assign unused_bits = ^wr_data[5:4];
  assign wr6     = {wr_data[7:6], wr_data[3:0]};
  assign new_req = pulse_en && (pulse_mask != NO_PULSE);
  assign ending  = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q     <= RESET_VALUE[7:6];
      lo_q     <= RESET_VALUE[3:0];
      drive_lo <= '0;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      wh_v     <= 1'b0;
      wh_d     <= '0;
      ph_v     <= 1'b0;
      ph_m     <= NO_PULSE;
    end else if (busy_q) begin
      if (new_req) begin
        ph_v <= 1'b1;
        ph_m <= pulse_mask;
      end
      if (ending) begin
        busy_q   <= 1'b0;
        drive_lo <= '0;
        wh_v     <= 1'b0;
        if (wr_en)     {hi_q, lo_q} <= wr6;
        else if (wh_v) {hi_q, lo_q} <= wh_d;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (wr_en) begin
          wh_v <= 1'b1;
          wh_d <= wr6;
        end
      end
    end else begin
      if (wr_en) {hi_q, lo_q} <= wr6;
      if (ph_v) begin
        busy_q   <= 1'b1;
        cnt_q    <= LAST;
        drive_lo <= ~ph_m;
        ph_v     <= new_req;
        if (new_req) ph_m <= pulse_mask;
      end else if (new_req) begin
        busy_q   <= 1'b1;
        cnt_q    <= LAST;
        drive_lo <= ~pulse_mask;
      end
    end
  end

  assign port_q = {hi_q, ~ibf, obf, lo_q & ~drive_lo};
  assign busy   = busy_q;

  always_comb begin
    if (rst_n) a_r4_count_bound: assert (cnt_q <= LAST);
  end

  a_r4_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !ph_v && new_req) |=> (busy && ((port_q[3:0] & ~$past(pulse_mask)) == 4'h0)));

  a_r6_full_mask_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !ph_v && pulse_en && pulse_mask == NO_PULSE) |=> !busy);

  a_r5_high_bits_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> $stable(port_q[7:6]));

  a_r1_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && wr_en) |=> (port_q[7:6] == $past(wr_data[7:6])));

  a_r8_gap_before_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ending && (ph_v || new_req)) |=> (!busy ##1 busy));
endmodule

// File: tb/test_kbc_output_port.sv
module test_kbc_output_port;
  localparam int P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       pulse_en = 1'b0;
  logic [3:0] pulse_mask = 4'hF;
  logic       obf = 1'b0;
  logic       ibf = 1'b0;
  logic [7:0] port_q;
  logic       busy;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  kbc_output_port #(.PULSE_CYCLES(P), .RESET_VALUE(8'hFF)) i_kbc_output_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pulse_en(pulse_en), .pulse_mask(pulse_mask), .obf(obf), .ibf(ibf),
    .port_q(port_q), .busy(busy)
  );

  // {wr_data, obf, ibf, expected port}
  localparam logic [17:0] VEC [6] = '{
    {8'hA5, 1'b1, 1'b0, 8'hB5},
    {8'h3C, 1'b0, 1'b1, 8'h0C},
    {8'hFF, 1'b0, 1'b0, 8'hEF},
    {8'h00, 1'b1, 1'b1, 8'h10},
    {8'h5A, 1'b1, 1'b0, 8'h7A},
    {8'hC3, 1'b0, 1'b1, 8'hC3}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_pulse(input logic [3:0] m);
    pulse_en = 1'b1; pulse_mask = m;
    tick();
    pulse_en = 1'b0; pulse_mask = 4'hF;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    #1;
    chk("R3 reset port", port_q, 8'hEF);
    chk("R3 reset busy", {7'b0, busy}, 8'h00);

    for (int i = 0; i < 6; i++) begin
      obf = VEC[i][9]; ibf = VEC[i][8];
      do_write(VEC[i][17:10]);
      chk("R1 idle write", port_q, VEC[i][7:0]);
      chk("R1 no busy on write", {7'b0, busy}, 8'h00);
    end
    obf = 1'b0; ibf = 1'b0;

    // R2: live flag reflection, no clock edge
    obf = 1'b1; ibf = 1'b1; #1;
    chk("R2 reflection", {2'b0, port_q[5:4], 4'b0}, 8'h10);
    obf = 1'b0; ibf = 1'b0; #1;
    chk("R2 reflection", {2'b0, port_q[5:4], 4'b0}, 8'h20);

    // R4/R5: basic pulse on bits 0 and 2
    do_write(8'hCF);
    do_pulse(4'b1010);
    for (int c = 0; c < P; c++) begin
      chk("R4 pulse busy", {7'b0, busy}, 8'h01);
      chk("R5 pulse port", port_q, 8'hEA);
      if (c < P - 1) tick();
    end
    tick();
    chk("R4 pulse ends busy", {7'b0, busy}, 8'h00);
    chk("R5 bits restored", port_q, 8'hEF);

    // R6: mask F does nothing
    do_pulse(4'hF);
    chk("R6 mask F busy", {7'b0, busy}, 8'h00);
    chk("R6 mask F port", port_q, 8'hEF);
    tick();
    chk("R6 mask F later", {7'b0, busy}, 8'h00);

    // R7: writes during a reset pulse are held, last one wins
    do_pulse(4'b1110);
    chk("R4 system reset low", {7'b0, port_q[0]}, 8'h00);
    do_write(8'h00);
    chk("R7 write held", port_q, 8'hEE);
    do_write(8'h42);
    chk("R7 write held", port_q, 8'hEE);
    for (int c = 0; c < P - 3; c++) tick();
    chk("R7 still busy", {7'b0, busy}, 8'h01);
    chk("R7 port during busy", port_q, 8'hEE);
    tick();
    chk("R7 applied after pulse", port_q, 8'h62);
    chk("R7 busy low", {7'b0, busy}, 8'h00);

    // R8: pulse requests during a pulse, last one held, one-cycle gap
    do_write(8'h0F);
    chk("R1 write", port_q, 8'h2F);
    do_pulse(4'b1101);
    chk("R4 first pulse", port_q, 8'h2D);
    do_pulse(4'b0111);
    do_pulse(4'b1011);
    for (int c = 0; c < P - 3; c++) tick();
    chk("R8 first pulse last cycle", port_q, 8'h2D);
    tick();
    chk("R8 gap busy", {7'b0, busy}, 8'h00);
    chk("R8 gap port", port_q, 8'h2F);
    tick();
    chk("R8 held pulse busy", {7'b0, busy}, 8'h01);
    chk("R8 held pulse port", port_q, 8'h2B);
    for (int c = 0; c < P - 1; c++) tick();
    chk("R8 held pulse last", port_q, 8'h2B);
    tick();
    chk("R8 held pulse done", {7'b0, busy}, 8'h00);
    chk("R5 restored after held", port_q, 8'h2F);

    // R9: simultaneous write and pulse
    wr_en = 1'b1; wr_data = 8'h8F; pulse_en = 1'b1; pulse_mask = 4'b1100;
    tick();
    wr_en = 1'b0; pulse_en = 1'b0; pulse_mask = 4'hF;
    chk("R9 combined", port_q, 8'hAC);
    chk("R9 combined busy", {7'b0, busy}, 8'h01);
    for (int c = 0; c < P; c++) tick();
    chk("R9 after pulse", port_q, 8'hAF);
    chk("R9 busy low", {7'b0, busy}, 8'h00);

    finish_run();
  end
endmodule